// File: doc/BRIEF.md
# Port change interrupt detector

This block monitors the high half of an 8-bit general-purpose input port and raises a sticky change flag whenever those pins no longer match a reference snapshot. Software takes the snapshot by reading the port through the register-side read strobe; the read also returns the synchronized port value. The low half of the port is readable but never takes part in change detection.

The flag is combined with a local change-interrupt enable and a global interrupt enable to form the interrupt request. Accepting an interrupt drops the global enable, and a return-from-interrupt strobe restores it. While the core sleeps, a set flag with the local enable on drives a wake request, whatever the global enable is. Software must read the port before it clears the flag. A clear with no read first leaves the pins unequal to the snapshot, so the flag comes back on the next cycle.

Top module: `port_change_irq`

## Requirements
- R1: Port bits 3..0 never affect the change flag; only bits 7..4 are compared against the reference.
- R2: A cycle with `rd_en_i` high loads the synchronized bits 7..4 into the reference at the next clock edge.
- R3: When the synchronized bits 7..4 differ from the reference, `flag_o` is 1 after the next clock edge.
- R4: If `flag_clr_i` is high in a cycle where a mismatch exists, the set wins and `flag_o` stays 1. This includes a read and a clear in the same cycle, because the compare uses the reference from before the read.
- R5: A `flag_clr_i` pulse with no mismatch present makes `flag_o` 0 after the next edge.
- R6: `irq_o` is 1 exactly when `flag_o`, the local enable and `gie_o` are all 1.
- R7: `irq_take_i` clears the global enable. Otherwise `irq_ret_i` sets it. Otherwise a write on `gie_we_i` loads `gie_wd_i`. Taking the interrupt has top priority.
- R8: `wake_o` is 1 when `sleep_i`, `flag_o` and the local enable are all 1, independent of `gie_o`.
- R9: While reset is held, and for two edges after `rst_n` rises, the reference, the flag and both enables are 0.
- R10: Each pin passes through two flops; a pin change at the input appears on `rd_data_o` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Raw port pins |
| rd_en_i | input | 1 | Port read strobe; reloads the reference |
| rd_data_o | output | 8 | Synchronized port value |
| flag_clr_i | input | 1 | Change flag clear |
| lie_we_i | input | 1 | Local enable write strobe |
| lie_wd_i | input | 1 | Local enable write value |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wd_i | input | 1 | Global enable write value |
| irq_take_i | input | 1 | Interrupt accepted by the core |
| irq_ret_i | input | 1 | Return from interrupt |
| sleep_i | input | 1 | Core is sleeping |
| flag_o | output | 1 | Sticky change flag |
| lie_o | output | 1 | Local change-interrupt enable |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to a sleeping core |

## Verification
The bench clears the flag without a fresh read and also with a read in the same cycle. In both cases the flag must stay set. A design that let the clear win would drop real events, and one that compared against the newly loaded reference would clear too early. It toggles only the low nibble and expects no flag, which catches a compare over the full port. It counts the exact edge on which a pin change reaches the read data and the flag, which exposes a missing or extra sync stage. It also checks the take-versus-return priority and that wake ignores the global enable.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    GE_HOLD  = 2'd0,
    GE_CLEAR = 2'd1,
    GE_SET   = 2'd2,
    GE_LOAD  = 2'd3
  } gie_op_e;

  function automatic gie_op_e gie_pick(input logic take, input logic ret, input logic we);
    if (take)      return GE_CLEAR;
    else if (ret)  return GE_SET;
    else if (we)   return GE_LOAD;
    else           return GE_HOLD;
  endfunction
endpackage

// File: rtl/pcd_rst_sync.sv
module pcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_sync = chain_q[1];
endmodule

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pcd_detect.sv
module pcd_detect #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] watch_i,
  input  logic          rd_en_i,
  input  logic          clr_i,
  output logic [WW-1:0] ref_o,
  output logic          mismatch_o,
  output logic          flag_o
);
  logic [WW-1:0] ref_q;
  logic          flag_q, flag_d;
  logic          mismatch;

  assign mismatch = (watch_i != ref_q);

  always_comb begin
    flag_d = flag_q;
    if (clr_i)    flag_d = 1'b0;
    if (mismatch) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_q <= '0;
    else if (rd_en_i) ref_q <= watch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign ref_o      = ref_q;
  assign mismatch_o = mismatch;
  assign flag_o     = flag_q;
endmodule

// File: rtl/pcd_enable.sv
module pcd_enable
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lie_we_i,
  input  logic lie_wd_i,
  input  logic gie_we_i,
  input  logic gie_wd_i,
  input  logic take_i,
  input  logic ret_i,
  output logic lie_o,
  output logic gie_o
);
  logic    lie_q;
  logic    gie_q, gie_d;
  gie_op_e op;

  assign op = gie_pick(take_i, ret_i, gie_we_i);

  always_comb begin
    unique case (op)
      GE_CLEAR: gie_d = 1'b0;
      GE_SET:   gie_d = 1'b1;
      GE_LOAD:  gie_d = gie_wd_i;
      default:  gie_d = gie_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lie_q <= 1'b0;
    else if (lie_we_i) lie_q <= lie_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign lie_o = lie_q;
  assign gie_o = gie_q;
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int PORT_W      = 8,
  parameter int WATCH_LO    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins_i,
  input  logic              rd_en_i,
  output logic [PORT_W-1:0] rd_data_o,
  input  logic              flag_clr_i,
  input  logic              lie_we_i,
  input  logic              lie_wd_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  input  logic              irq_take_i,
  input  logic              irq_ret_i,
  input  logic              sleep_i,
  output logic              flag_o,
  output logic              lie_o,
  output logic              gie_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int WATCH_W = PORT_W - WATCH_LO;

  logic                rst_n_int;
  logic [PORT_W-1:0]   sync_q;
  logic [WATCH_W-1:0]  watch_w;
  logic [WATCH_W-1:0]  ref_w;
  logic                mismatch_w;
  logic                flag_w, lie_w, gie_w;

  pcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pcd_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pins_i),
    .dout  (sync_q)
  );

  assign watch_w = sync_q[PORT_W-1:WATCH_LO];

  pcd_detect #(.WW(WATCH_W)) u_det (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .watch_i    (watch_w),
    .rd_en_i    (rd_en_i),
    .clr_i      (flag_clr_i),
    .ref_o      (ref_w),
    .mismatch_o (mismatch_w),
    .flag_o     (flag_w)
  );

  pcd_enable u_en (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .lie_we_i (lie_we_i),
    .lie_wd_i (lie_wd_i),
    .gie_we_i (gie_we_i),
    .gie_wd_i (gie_wd_i),
    .take_i   (irq_take_i),
    .ret_i    (irq_ret_i),
    .lie_o    (lie_w),
    .gie_o    (gie_w)
  );

  assign rd_data_o = sync_q;
  assign flag_o    = flag_w;
  assign lie_o     = lie_w;
  assign gie_o     = gie_w;
  assign irq_o     = flag_w & lie_w & gie_w;
  assign wake_o    = sleep_i & flag_w & lie_w;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [WW-1:0] watch,
  input logic [WW-1:0] ref_v,
  input logic          mismatch,
  input logic          flag,
  input logic          gie,
  input logic          rd_en,
  input logic          clr,
  input logic          take,
  input logic          ret
);
  // R2
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (ref_v == $past(watch)));

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && clr) |=> flag);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mismatch && clr) |=> !flag);

  // R7
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);

  // R7
  ret_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> gie);
endmodule

bind port_change_irq pcd_checker #(.WW(WATCH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .watch    (watch_w),
  .ref_v    (ref_w),
  .mismatch (mismatch_w),
  .flag     (flag_w),
  .gie      (gie_w),
  .rd_en    (rd_en_i),
  .clr      (flag_clr_i),
  .take     (irq_take_i),
  .ret      (irq_ret_i)
);

// File: tb/port_change_irq_bench.sv
`timescale 1ns/1ps
module port_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_i = 8'h00;
  logic       rd_en_i = 1'b0, flag_clr_i = 1'b0;
  logic       lie_we_i = 1'b0, lie_wd_i = 1'b0;
  logic       gie_we_i = 1'b0, gie_wd_i = 1'b0;
  logic       irq_take_i = 1'b0, irq_ret_i = 1'b0, sleep_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       flag_o, lie_o, gie_o, irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit live  = 1'b0;

  always #4 clk = ~clk;

  port_change_irq u_port_change_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .flag_clr_i(flag_clr_i),
    .lie_we_i(lie_we_i), .lie_wd_i(lie_wd_i),
    .gie_we_i(gie_we_i), .gie_wd_i(gie_wd_i),
    .irq_take_i(irq_take_i), .irq_ret_i(irq_ret_i), .sleep_i(sleep_i),
    .flag_o(flag_o), .lie_o(lie_o), .gie_o(gie_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // behavioural reference model
  logic [7:0] m_pipe[$] = '{8'h00, 8'h00};
  logic [3:0] m_ref = 4'h0;
  bit m_flag = 0, m_lie = 0, m_gie = 0;
  int rel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pipe = '{8'h00, 8'h00}; m_ref = 4'h0; m_flag = 0; m_lie = 0; m_gie = 0; rel = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      logic [7:0] cur;
      bit diff;
      cur  = m_pipe[0];
      diff = (cur[7:4] != m_ref);
      if (diff) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
      if (rd_en_i) m_ref = cur[7:4];
      if (lie_we_i) m_lie = lie_wd_i;
      if (irq_take_i) m_gie = 0;
      else if (irq_ret_i) m_gie = 1;
      else if (gie_we_i) m_gie = gie_wd_i;
      void'(m_pipe.pop_front());
      m_pipe.push_back(pins_i);
    end
    live = 1'b1;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R10 rd_data", rd_data_o, m_pipe[0]);
    chk("R3 flag", {7'd0, flag_o}, {7'd0, m_flag});
    chk("R9 lie", {7'd0, lie_o}, {7'd0, m_lie});
    chk("R7 gie", {7'd0, gie_o}, {7'd0, m_gie});
    chk("R6 irq", {7'd0, irq_o}, {7'd0, m_flag & m_lie & m_gie});
    chk("R8 wake", {7'd0, wake_o}, {7'd0, sleep_i & m_flag & m_lie});
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R9: still held in reset two edges after release
    chk("R9 flag", {7'd0, flag_o}, 8'h00);
    chk("R9 gie", {7'd0, gie_o}, 8'h00);
    tick(3);
    // R1: low nibble only
    pins_i = 8'h0F; tick(6);
    chk("R1 low nibble ignored", {7'd0, flag_o}, 8'h00);
    // R10 / R3 timing
    pins_i = 8'h1F; tick(2);
    chk("R10 two-edge delay", rd_data_o, 8'h1F);
    chk("R3 not yet", {7'd0, flag_o}, 8'h00);
    tick(1);
    chk("R3 flag set", {7'd0, flag_o}, 8'h01);
    // R4: clear without read
    flag_clr_i = 1; tick(1); flag_clr_i = 0;
    chk("R4 set wins", {7'd0, flag_o}, 8'h01);
    // R2 / R5: read then clear
    rd_en_i = 1; tick(1); rd_en_i = 0;
    flag_clr_i = 1; tick(1); flag_clr_i = 0;
    chk("R5 cleared", {7'd0, flag_o}, 8'h00);
    tick(3);
    chk("R2 reference loaded", {7'd0, flag_o}, 8'h00);
    // R4: read and clear in the same cycle
    pins_i = 8'h3F; tick(3);
    rd_en_i = 1; flag_clr_i = 1; tick(1); rd_en_i = 0; flag_clr_i = 0;
    chk("R4 read+clear same cycle", {7'd0, flag_o}, 8'h01);
    flag_clr_i = 1; tick(1); flag_clr_i = 0;
    chk("R5 cleared after read", {7'd0, flag_o}, 8'h00);
    // R6 / R7
    lie_we_i = 1; lie_wd_i = 1; gie_we_i = 1; gie_wd_i = 1; tick(1);
    lie_we_i = 0; gie_we_i = 0;
    pins_i = 8'h2F; tick(3);
    chk("R6 irq raised", {7'd0, irq_o}, 8'h01);
    irq_take_i = 1; tick(1); irq_take_i = 0;
    chk("R7 take clears", {7'd0, gie_o}, 8'h00);
    chk("R6 irq masked", {7'd0, irq_o}, 8'h00);
    irq_ret_i = 1; tick(1); irq_ret_i = 0;
    chk("R7 return sets", {7'd0, gie_o}, 8'h01);
    irq_take_i = 1; irq_ret_i = 1; tick(1); irq_take_i = 0; irq_ret_i = 0;
    chk("R7 take beats return", {7'd0, gie_o}, 8'h00);
    // R8
    sleep_i = 1; tick(1);
    chk("R8 wake without gie", {7'd0, wake_o}, 8'h01);
    lie_we_i = 1; lie_wd_i = 0; tick(1); lie_we_i = 0;
    chk("R8 wake needs lie", {7'd0, wake_o}, 8'h00);
    sleep_i = 0;
    // random phase, model compared on every clock
    for (int k = 0; k < 2000; k++) begin
      pins_i     = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pins_i;
      rd_en_i    = ($urandom_range(0, 5) == 0);
      flag_clr_i = ($urandom_range(0, 4) == 0);
      lie_we_i   = ($urandom_range(0, 7) == 0); lie_wd_i = 1'($urandom);
      gie_we_i   = ($urandom_range(0, 7) == 0); gie_wd_i = 1'($urandom);
      irq_take_i = ($urandom_range(0, 9) == 0);
      irq_ret_i  = ($urandom_range(0, 9) == 0);
      sleep_i    = 1'($urandom);
      tick(1);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule